// File: doc/BRIEF.md
# Round-Robin Execution Slot Scheduler

This block shares one instruction issue port among six hardware execution slots. A single supervisor context and up to six worker contexts compete for those slots. A pointer visits the slots in a fixed cyclic order, one slot per clock. The block reports which slot is issuing and which context owns it.

After reset the supervisor owns every slot. Each worker that is launched takes over one slot. When that worker terminates, the slot goes back to the supervisor. The supervisor's share of issue cycles therefore grows and shrinks with the number of resident workers. With six workers resident the supervisor is fully suspended and a stall flag is raised.

Launch requests are answered in the same cycle with an accept or a reject. Ownership changes apply from the next clock. The block also flags an exception whenever the supervisor tries to issue an instruction bound for the floating-point pipeline.

Top module: `slot_sched`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `slot_sel` equals 6'b000001 (slot 0) and all slots belong to the supervisor. In that state `ctx_id` is 0 and `sup_stall` is 0.
- R2: `slot_sel` is one-hot, with bit i meaning slot i. It advances from slot i to slot (i+1) mod 6 on every clock and returns to slot 0 after slot 5.
- R3: `ctx_id` names the owner of the selected slot: 0 means the supervisor and w+1 means worker w. An accepted launch of worker w claims the lowest-numbered free slot, and that slot reports w+1 from the next clock on.
- R4: A pulse on `term_req[w]` for a running worker returns that worker's slot to the supervisor from the next clock. A pulse for a worker that is not running has no effect.
- R5: `sup_stall` is 1 exactly when all six slots hold workers. While it is 1, `ctx_id` is never 0.
- R6: `aux_exc` is 1 in a cycle exactly when `aux_op` is 1 and the selected slot belongs to the supervisor. It is never raised for a worker's slot.
- R7: A launch is rejected (`launch_nak`=1) in three cases: no slot is free after this cycle's terminations are applied; the requested id is 6 or 7; or the requested worker is running and is not terminating in the same cycle. A rejected launch leaves slot ownership unchanged.
- R8: A launch and terminations in the same cycle are both applied. A slot freed by a termination may be claimed by that launch, and a worker terminating in that cycle may be relaunched by it.
- R9: `launch_ack` and `launch_nak` respond combinationally in the cycle that `launch_req` is 1. Exactly one of them is 1 then, and neither is 1 when `launch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_req | input | 1 | Request to launch a worker this cycle |
| launch_wid | input | 3 | Worker id to launch |
| term_req | input | 6 | One bit per worker: that worker terminates this cycle |
| aux_op | input | 1 | Instruction issuing from the selected slot targets the floating-point pipeline |
| slot_sel | output | 6 | One-hot select of the slot issuing this cycle |
| ctx_id | output | 3 | Owner of the selected slot: 0 supervisor, w+1 worker w |
| sup_stall | output | 1 | All slots held by workers; supervisor suspended |
| launch_ack | output | 1 | Launch accepted |
| launch_nak | output | 1 | Launch rejected |
| aux_exc | output | 1 | Supervisor attempted a floating-point issue |

## Verification
The bench fills all six slots and then tries a seventh launch while the slots are full. A design that miscounted free slots would accept that launch and overwrite a resident worker. The bench also terminates and relaunches the same worker in one cycle, and terminates two workers while an already-running id asks to launch. A design that ignored same-cycle terminations would reject the relaunch or keep a stale owner. A few cases target specific mistakes: terminations for idle workers, an out-of-range id, and floating-point issues at every rotation position. These catch a design that freed a slot it should not have, accepted an id 7, or raised the exception for a worker. An asynchronous reset in the middle of a run must put the rotation back at slot 0 immediately.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
  localparam int unsigned DEF_SLOTS   = 6;
  localparam int unsigned DEF_WORKERS = 6;
  // context id reported for the supervisor; worker w reports w + 1
  localparam int unsigned SUP_CTX_ID  = 0;
endpackage

// File: rtl/slot_sched_rotator.sv
module slot_sched_rotator #(
  parameter int unsigned NUM_SLOTS = slot_sched_pkg::DEF_SLOTS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [NUM_SLOTS-1:0] ptr_oh
);
  logic [NUM_SLOTS-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = {ptr_q[NUM_SLOTS-2:0], ptr_q[NUM_SLOTS-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= {{(NUM_SLOTS-1){1'b0}}, 1'b1};
    else        ptr_q <= ptr_d;
  end

  assign ptr_oh = ptr_q;

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ptr_q) == 1);

  p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ptr_q == {$past(ptr_q[NUM_SLOTS-2:0]), $past(ptr_q[NUM_SLOTS-1])});
endmodule

// File: rtl/slot_sched_table.sv
module slot_sched_table #(
  parameter int unsigned NUM_SLOTS   = slot_sched_pkg::DEF_SLOTS,
  parameter int unsigned NUM_WORKERS = slot_sched_pkg::DEF_WORKERS,
  localparam int unsigned WID_W      = $clog2(NUM_WORKERS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            claim_en,
  input  logic [NUM_SLOTS-1:0]            claim_oh,
  input  logic [WID_W-1:0]                claim_wid,
  input  logic [NUM_WORKERS-1:0]          term_req,
  output logic [NUM_SLOTS-1:0]            busy,
  output logic [NUM_SLOTS-1:0][WID_W-1:0] slot_wid,
  output logic [NUM_SLOTS-1:0]            rel,
  output logic [NUM_WORKERS-1:0]          run_vec
);
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             busy_r, busy_d, take, hit, rel_s;
    logic [WID_W-1:0] wid_r;

    always_comb begin
      take = claim_en & claim_oh[s];
      hit  = 1'b0;
      for (int w = 0; w < NUM_WORKERS; w++) begin
        if (wid_r == WID_W'(w)) hit = term_req[w];
      end
      rel_s  = busy_r & hit;
      busy_d = busy_r;
      if (take)       busy_d = 1'b1;
      else if (rel_s) busy_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        wid_r  <= '0;
      end else begin
        busy_r <= busy_d;
        if (take) wid_r <= claim_wid;
      end
    end

    assign busy[s]     = busy_r;
    assign slot_wid[s] = wid_r;
    assign rel[s]      = rel_s;
  end

  always_comb begin
    run_vec = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      for (int w = 0; w < NUM_WORKERS; w++) begin
        if (busy[s] && slot_wid[s] == WID_W'(w)) run_vec[w] = 1'b1;
      end
    end
  end

  // R7: with no claim and no termination, ownership holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!claim_en && term_req == '0) |=> $stable(busy));

  // R3: a claimed slot is held by a worker on the next cycle
  p_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim_en |=> (busy & $past(claim_oh)) != '0);

  // R4: a released slot that is not re-claimed is free next cycle
  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rel != '0 && !claim_en) |=> (busy & $past(rel)) == '0);
endmodule

// File: rtl/slot_sched_admit.sv
module slot_sched_admit #(
  parameter int unsigned NUM_SLOTS   = slot_sched_pkg::DEF_SLOTS,
  parameter int unsigned NUM_WORKERS = slot_sched_pkg::DEF_WORKERS,
  localparam int unsigned WID_W      = $clog2(NUM_WORKERS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_req,
  input  logic [WID_W-1:0]       launch_wid,
  input  logic [NUM_WORKERS-1:0] term_req,
  input  logic [NUM_SLOTS-1:0]   busy,
  input  logic [NUM_SLOTS-1:0]   rel,
  input  logic [NUM_WORKERS-1:0] run_vec,
  output logic                   claim_en,
  output logic [NUM_SLOTS-1:0]   claim_oh,
  output logic                   launch_ack,
  output logic                   launch_nak
);
  logic [NUM_SLOTS-1:0] free;
  logic                 id_ok, id_busy;

  always_comb begin
    free     = ~busy | rel;
    claim_oh = free & (~free + NUM_SLOTS'(1));
    id_ok    = {1'b0, launch_wid} < (WID_W+1)'(NUM_WORKERS);
    id_busy  = 1'b0;
    for (int w = 0; w < NUM_WORKERS; w++) begin
      if (launch_wid == WID_W'(w)) id_busy = run_vec[w] & ~term_req[w];
    end
    claim_en   = launch_req & (free != '0) & id_ok & ~id_busy;
    launch_ack = claim_en;
    launch_nak = launch_req & ~claim_en;
  end

  p_full_nak_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_req && (busy & ~rel) == '1) |-> launch_nak);

  p_one_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch_req |-> (launch_ack ^ launch_nak));

  p_idle_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_req |-> (!launch_ack && !launch_nak));
endmodule

// File: rtl/slot_sched.sv
module slot_sched #(
  parameter int unsigned NUM_SLOTS   = slot_sched_pkg::DEF_SLOTS,
  parameter int unsigned NUM_WORKERS = slot_sched_pkg::DEF_WORKERS,
  localparam int unsigned WID_W      = $clog2(NUM_WORKERS),
  localparam int unsigned CTX_W      = $clog2(NUM_WORKERS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   launch_req,
  input  logic [WID_W-1:0]       launch_wid,
  input  logic [NUM_WORKERS-1:0] term_req,
  input  logic                   aux_op,
  output logic [NUM_SLOTS-1:0]   slot_sel,
  output logic [CTX_W-1:0]       ctx_id,
  output logic                   sup_stall,
  output logic                   launch_ack,
  output logic                   launch_nak,
  output logic                   aux_exc
);
  import slot_sched_pkg::*;

  logic [NUM_SLOTS-1:0]            busy, rel, claim_oh;
  logic [NUM_SLOTS-1:0][WID_W-1:0] slot_wid;
  logic [NUM_WORKERS-1:0]          run_vec;
  logic                            claim_en, cur_busy;
  logic [WID_W-1:0]                cur_wid;

  slot_sched_rotator #(.NUM_SLOTS(NUM_SLOTS)) i_rot (
    .clk(clk), .rst_n(rst_n), .ptr_oh(slot_sel));

  slot_sched_table #(.NUM_SLOTS(NUM_SLOTS), .NUM_WORKERS(NUM_WORKERS)) i_tbl (
    .clk(clk), .rst_n(rst_n), .claim_en(claim_en), .claim_oh(claim_oh),
    .claim_wid(launch_wid), .term_req(term_req), .busy(busy),
    .slot_wid(slot_wid), .rel(rel), .run_vec(run_vec));

  slot_sched_admit #(.NUM_SLOTS(NUM_SLOTS), .NUM_WORKERS(NUM_WORKERS)) i_adm (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .launch_wid(launch_wid),
    .term_req(term_req), .busy(busy), .rel(rel), .run_vec(run_vec),
    .claim_en(claim_en), .claim_oh(claim_oh),
    .launch_ack(launch_ack), .launch_nak(launch_nak));

  always_comb begin
    cur_busy = 1'b0;
    cur_wid  = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (slot_sel[s]) begin
        cur_busy = busy[s];
        cur_wid  = slot_wid[s];
      end
    end
    ctx_id    = cur_busy ? CTX_W'(cur_wid) + CTX_W'(1) : CTX_W'(SUP_CTX_ID);
    sup_stall = &busy;
    aux_exc   = aux_op & ~cur_busy;
  end

  p_stall_worker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_stall |-> ctx_id != CTX_W'(SUP_CTX_ID));

  p_sup_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_op && ctx_id == CTX_W'(SUP_CTX_ID)) |-> aux_exc);

  p_worker_no_exc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_id != CTX_W'(SUP_CTX_ID)) |-> !aux_exc);
endmodule

// File: tb/test_slot_sched.sv
module test_slot_sched;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       launch_req;
  logic [2:0] launch_wid;
  logic [5:0] term_req;
  logic       aux_op;
  logic [5:0] slot_sel;
  logic [2:0] ctx_id;
  logic       sup_stall, launch_ack, launch_nak, aux_exc;

  always #4 clk = ~clk;  // 125 MHz

  slot_sched i_slot_sched (
    .clk(clk), .rst_n(rst_n), .launch_req(launch_req), .launch_wid(launch_wid),
    .term_req(term_req), .aux_op(aux_op), .slot_sel(slot_sel), .ctx_id(ctx_id),
    .sup_stall(sup_stall), .launch_ack(launch_ack), .launch_nak(launch_nak),
    .aux_exc(aux_exc));

  typedef struct packed {
    logic       ln;
    logic [2:0] wid;
    logic [5:0] tm;
    logic       ax;
    logic       ack;
    logic       nak;
    logic       stl;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},  // supervisor fp -> exc
    '{1'b1, 3'd2, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd2, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0},  // already running
    '{1'b1, 3'd0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd5, 6'h00, 1'b1, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd1, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd3, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd4, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},  // sixth worker
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b1},  // stalled
    '{1'b1, 3'd0, 6'h00, 1'b0, 1'b0, 1'b1, 1'b1},  // full
    '{1'b1, 3'd5, 6'h20, 1'b0, 1'b1, 1'b0, 1'b1},  // relaunch while ending
    '{1'b0, 3'd0, 6'h08, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd3, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 3'd4, 6'h03, 1'b0, 1'b0, 1'b1, 1'b1},  // running id, terms applied
    '{1'b1, 3'd0, 6'h01, 1'b0, 1'b1, 1'b0, 1'b0},  // idle term ignored
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h3f, 1'b0, 1'b0, 1'b0, 1'b0},  // all end
    '{1'b1, 3'd1, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 3'd7, 6'h00, 1'b0, 1'b0, 1'b1, 1'b0}   // id out of range
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int pos;
  int own [6];

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic vec_t mk(input logic ln, input logic [2:0] wid,
                              input logic [5:0] tm, input logic ax,
                              input logic ack, input logic nak, input logic stl);
    vec_t v;
    v = '{ln, wid, tm, ax, ack, nak, stl};
    return v;
  endfunction

  task automatic model_reset();
    pos = 0;
    for (int s = 0; s < 6; s++) own[s] = -1;
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic step(input vec_t v, input string why);
    int exp_ctx;
    launch_req = v.ln; launch_wid = v.wid; term_req = v.tm; aux_op = v.ax;
    #1;
    exp_ctx = (own[pos] < 0) ? 0 : own[pos] + 1;
    chk({why, " R2 slot_sel"}, slot_sel, 1 << pos);
    chk({why, " R3 ctx_id"}, ctx_id, exp_ctx);
    chk({why, " R5 sup_stall"}, sup_stall, v.stl);
    chk({why, " R7 launch_nak"}, launch_nak, v.nak);
    chk({why, " R9 launch_ack"}, launch_ack, v.ack);
    chk({why, " R6 aux_exc"}, aux_exc, (v.ax && own[pos] < 0) ? 1 : 0);
    @(posedge clk);
    for (int s = 0; s < 6; s++)
      if (own[s] >= 0 && v.tm[own[s]]) own[s] = -1;
    if (v.ack) begin
      for (int s = 0; s < 6; s++)
        if (own[s] < 0) begin own[s] = int'(v.wid); break; end
    end
    pos = (pos + 1) % 6;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; launch_req = 1'b0; launch_wid = '0; term_req = '0; aux_op = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 slot_sel in reset", slot_sel, 1);
    chk("R1 ctx_id in reset", ctx_id, 0);
    chk("R1 sup_stall in reset", sup_stall, 0);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();

    for (int i = 0; i < NV; i++) step(TBL[i], "vec");

    // asynchronous reset in mid-run, with workers resident
    step(mk(1'b1, 3'd4, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0), "pre");
    rst_n = 1'b0;
    #1;
    chk("R1 slot_sel async reset", slot_sel, 1);
    chk("R1 ctx_id async reset", ctx_id, 0);
    chk("R1 sup_stall async reset", sup_stall, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    for (int i = 0; i < 6; i++) step(mk(1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0), "R1");

    step(mk(1'b1, 3'd0, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0), "R3");
    step(mk(1'b1, 3'd1, 6'h00, 1'b0, 1'b1, 1'b0, 1'b0), "R3");
    step(mk(1'b1, 3'd2, 6'h01, 1'b0, 1'b1, 1'b0, 1'b0), "R8");
    step(mk(1'b0, 3'd0, 6'h02, 1'b0, 1'b0, 1'b0, 1'b0), "R4");
    for (int i = 0; i < 6; i++) step(mk(1'b0, 3'd0, 6'h00, 1'b1, 1'b0, 1'b0, 1'b0), "R4");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule